// File: doc/BRIEF.md
# Single-Cell Lithium Charge Sequencer

This block is the digital sequencing core of a single-cell lithium charger. Analog comparators upstream report whether each supply input is present, whether the adapter input is over its voltage limit, where the battery voltage sits against its low and recharge thresholds, and whether the current loop is in voltage regulation. They also report whether the current has dropped below the taper or termination levels, whether the cell temperature is inside its window, whether the die is too hot, and whether a new battery was inserted. The sequencer picks the supply, decides which current mode the analog loop should run, and keeps a status word that host software reads and acknowledges.

All safety timing is counted in units of a slow `tick_i` strobe. There are four timers: the USB start delay, the precharge limit, the fast-charge limit and the taper window. Their lengths are parameters. A cell temperature excursion or a die overtemperature stops charging at once. The running timers freeze and continue from the same counts when the condition clears. A timeout fault leaves the charger sourcing only a small detect current until software, a battery swap or a charger reset releases it.

Top module: `li_chg_seq`

## Requirements
- R1: `src_sel_o` follows the inputs one clock later with 0 = none, 1 = adapter, 2 = USB. The adapter is chosen whenever it is valid, even with USB present. USB is chosen only when the adapter is not valid.
- R2: The adapter input is valid only when `ac_ok_i` is high and `ac_ovp_i` is low. `pg_en_o` goes high one clock after a valid adapter or USB input appears, provided `chg_rst_i` is low.
- R3: Starting from idle on USB, charging begins on the `USB_DLY_TICKS`-th tick. Starting on the adapter, it begins on the second clock with no tick needed.
- R4: `cur_scale_o` is {0, `ac_derate_i`} on the adapter and {1, 0, `usb_hi_i`} on USB. `ac_derate_i` has no effect on USB. Its values 0/1/2/3 mean 100/75/50/25 % of the adapter current. `usb_hi_i` 0/1 means the low/high USB limit.
- R5: `cur_mode_o` uses 0 = off, 1 = detect, 2 = precharge, 3 = fast. A start with `bat_low_i` high enters precharge (status bit 0), otherwise fast (status bit 1). Precharge moves to fast on the clock after `bat_low_i` falls.
- R6: The `PRE_TICKS`-th unsuspended tick in precharge, with the battery still low, enters fault. Status bit 5 goes high and `cur_mode_o` becomes detect.
- R7: Fault is left only on `fault_clr_i`, `bat_swap_i` or `chg_rst_i`. Losing and regaining the supply does not clear it.
- R8: While `temp_ok_i` is low or `tj_hot_i` is high in precharge or fast, `cur_mode_o` is off, no timer advances, and sticky status bit 6 is set. Charging resumes with the previous timer counts.
- R9: The fast timer counts only when `tmr_en_i` is high. It restarts when `in_vreg_i` falls. Its `FAST_TICKS`-th tick enters fault.
- R10: With `tmr_en_i` and `in_vreg_i` high, ticks while `below_taper_i` is high count the taper window, which restarts when `below_taper_i` drops. Its `TAPER_TICKS`-th tick ends charging (status bit 2) and sets sticky bit 3.
- R11: `below_term_i` in fast ends charging on the next clock, regardless of timers, and sets sticky bit 4.
- R12: After charging has ended, `bat_rch_i` restarts charging on the next clock and clears bits 3 and 4.
- R13: `chg_rst_i` forces `pg_en_o` low on the next clock and returns the charger to idle with current off.
- R14: `int_ack_i` bits 0/1/2 clear sticky status bits 3/4/6 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer time-base strobe |
| ac_ok_i | input | 1 | Adapter input present |
| usb_ok_i | input | 1 | USB input present |
| ac_ovp_i | input | 1 | Adapter above overvoltage limit |
| bat_low_i | input | 1 | Battery below low threshold |
| bat_rch_i | input | 1 | Battery below recharge threshold |
| in_vreg_i | input | 1 | Loop in voltage regulation |
| below_taper_i | input | 1 | Current below taper level |
| below_term_i | input | 1 | Current below termination level |
| temp_ok_i | input | 1 | Cell temperature in window |
| tj_hot_i | input | 1 | Die overtemperature |
| bat_swap_i | input | 1 | Battery replacement detected |
| usb_hi_i | input | 1 | Select high USB current limit |
| tmr_en_i | input | 1 | Enable fast and taper timers |
| chg_rst_i | input | 1 | Hold charger in reset |
| ac_derate_i | input | 2 | Adapter current reduction step |
| fault_clr_i | input | 1 | Software fault clear pulse |
| int_ack_i | input | 3 | Sticky status acknowledge |
| src_sel_o | output | 2 | Selected input source |
| cur_mode_o | output | 2 | Current mode code |
| cur_scale_o | output | 3 | Current scale code |
| pg_en_o | output | 1 | Power-good drive enable |
| status_o | output | 8 | Status: 0 pre, 1 fast, 2 done, 3 taper, 4 term, 5 fault, 6 suspend, 7 USB |

## Verification
Source selection is driven with a vector table covering every mix of adapter, USB and overvoltage. The table separates priority from validity and shows that the derating field reaches only the adapter code. The charging path is then exercised by walking the cell through precharge, fast, taper and termination with short timers. Each timer is driven to one tick before expiry and then to expiry, so a count that is off by one or a missed restart is caught. A suspension is inserted mid-count, and the number of remaining ticks to fault shows whether counts froze or were reset.

// File: rtl/li_chg_pkg.sv
package li_chg_pkg;
  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_AC = 2'd1, SRC_USB = 2'd2} src_e;
  typedef enum logic [1:0] {CUR_OFF = 2'd0, CUR_DET = 2'd1, CUR_PRE = 2'd2, CUR_FAST = 2'd3} cur_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_PRE, ST_FAST, ST_DONE, ST_FAULT
  } chg_st_e;
  localparam int unsigned ST_W = 8;
  localparam int unsigned ACK_W = 3;
endpackage

// File: rtl/li_chg_tmr.sv
module li_chg_tmr #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic exp_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign exp_o = run_i && !clr_i && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/li_chg_src.sv
module li_chg_src
  import li_chg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ac_ok_i,
  input  logic       usb_ok_i,
  input  logic       ac_ovp_i,
  input  logic       chg_rst_i,
  input  logic       usb_hi_i,
  input  logic [1:0] ac_derate_i,
  output src_e       src_o,
  output logic       pg_o,
  output logic [2:0] scale_o
);
  logic ac_valid;
  src_e src_d;

  assign ac_valid = ac_ok_i && !ac_ovp_i;

  always_comb begin
    if (ac_valid)      src_d = SRC_AC;
    else if (usb_ok_i) src_d = SRC_USB;
    else               src_d = SRC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= SRC_NONE;
      pg_o  <= 1'b0;
    end else begin
      src_o <= src_d;
      pg_o  <= (src_d != SRC_NONE) && !chg_rst_i;
    end
  end

  always_comb begin
    case (src_o)
      SRC_AC:  scale_o = {1'b0, ac_derate_i};
      SRC_USB: scale_o = {2'b10, usb_hi_i};
      default: scale_o = 3'b000;
    endcase
  end
endmodule

// File: rtl/li_chg_fsm.sv
module li_chg_fsm
  import li_chg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  src_e             src_i,
  input  logic             en_i,
  input  logic             chg_rst_i,
  input  logic             tick_i,
  input  logic             bat_low_i,
  input  logic             bat_rch_i,
  input  logic             in_vreg_i,
  input  logic             below_taper_i,
  input  logic             below_term_i,
  input  logic             temp_ok_i,
  input  logic             tj_hot_i,
  input  logic             bat_swap_i,
  input  logic             tmr_en_i,
  input  logic             fault_clr_i,
  input  logic [ACK_W-1:0] int_ack_i,
  input  logic             usb_exp_i,
  input  logic             pre_exp_i,
  input  logic             fast_exp_i,
  input  logic             tap_exp_i,
  output logic             usb_run_o,
  output logic             usb_clr_o,
  output logic             pre_run_o,
  output logic             pre_clr_o,
  output logic             fast_run_o,
  output logic             fast_clr_o,
  output logic             tap_run_o,
  output logic             tap_clr_o,
  output cur_e             cur_o,
  output logic [ST_W-1:0]  status_o
);
  chg_st_e st_q, st_d, start_st;
  logic    susp, vreg_q, vreg_fell, go_tap, go_term, restart;
  logic    tap_st_q, term_st_q, susp_st_q;

  assign susp      = (st_q == ST_PRE || st_q == ST_FAST) && (!temp_ok_i || tj_hot_i);
  assign vreg_fell = vreg_q && !in_vreg_i;
  assign start_st  = bat_low_i ? ST_PRE : ST_FAST;

  always_comb begin
    st_d    = st_q;
    go_tap  = 1'b0;
    go_term = 1'b0;
    restart = 1'b0;
    case (st_q)
      ST_IDLE: if (en_i) st_d = (src_i == SRC_USB) ? ST_WAIT : start_st;
      ST_WAIT: begin
        if (!en_i)                               st_d = ST_IDLE;
        else if (src_i == SRC_AC || usb_exp_i)   st_d = start_st;
      end
      ST_PRE: begin
        if (!en_i)            st_d = ST_IDLE;
        else if (!susp) begin
          if (!bat_low_i)     st_d = ST_FAST;
          else if (pre_exp_i) st_d = ST_FAULT;
        end
      end
      ST_FAST: begin
        if (!en_i) st_d = ST_IDLE;
        else if (!susp) begin
          if (below_term_i) begin
            st_d    = ST_DONE;
            go_term = 1'b1;
          end else if (tap_exp_i) begin
            st_d   = ST_DONE;
            go_tap = 1'b1;
          end else if (fast_exp_i) st_d = ST_FAULT;
        end
      end
      ST_DONE: begin
        if (!en_i) st_d = ST_IDLE;
        else if (bat_rch_i) begin
          st_d    = start_st;
          restart = 1'b1;
        end
      end
      ST_FAULT: if (bat_swap_i || fault_clr_i || chg_rst_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      vreg_q    <= 1'b0;
      tap_st_q  <= 1'b0;
      term_st_q <= 1'b0;
      susp_st_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      vreg_q <= in_vreg_i;
      if (go_tap)                       tap_st_q <= 1'b1;
      else if (restart || int_ack_i[0]) tap_st_q <= 1'b0;
      if (go_term)                      term_st_q <= 1'b1;
      else if (restart || int_ack_i[1]) term_st_q <= 1'b0;
      if (susp)                         susp_st_q <= 1'b1;
      else if (int_ack_i[2])            susp_st_q <= 1'b0;
    end
  end

  // timer controls: counts freeze in suspend, clear on leaving the owning state
  assign usb_run_o  = (st_q == ST_WAIT) && tick_i;
  assign usb_clr_o  = (st_q != ST_WAIT);
  assign pre_run_o  = (st_q == ST_PRE) && !susp && tick_i;
  assign pre_clr_o  = (st_q != ST_PRE);
  assign fast_run_o = (st_q == ST_FAST) && !susp && tmr_en_i && tick_i;
  assign fast_clr_o = (st_q != ST_FAST) || !tmr_en_i || vreg_fell;
  assign tap_run_o  = fast_run_o;
  assign tap_clr_o  = (st_q != ST_FAST) || !tmr_en_i || !in_vreg_i || !below_taper_i;

  always_comb begin
    case (st_q)
      ST_PRE:   cur_o = (en_i && !susp) ? CUR_PRE : CUR_OFF;
      ST_FAST:  cur_o = (en_i && !susp) ? CUR_FAST : CUR_OFF;
      ST_FAULT: cur_o = en_i ? CUR_DET : CUR_OFF;
      default:  cur_o = CUR_OFF;
    endcase
  end

  assign status_o = {src_i == SRC_USB, susp_st_q, st_q == ST_FAULT, term_st_q,
                     tap_st_q, st_q == ST_DONE, st_q == ST_FAST, st_q == ST_PRE};
endmodule

// File: rtl/li_chg_seq.sv
module li_chg_seq
  import li_chg_pkg::*;
#(
  parameter int unsigned USB_DLY_TICKS = 64,
  parameter int unsigned PRE_TICKS     = 1800,
  parameter int unsigned FAST_TICKS    = 18000,
  parameter int unsigned TAPER_TICKS   = 900
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ac_ok_i,
  input  logic             usb_ok_i,
  input  logic             ac_ovp_i,
  input  logic             bat_low_i,
  input  logic             bat_rch_i,
  input  logic             in_vreg_i,
  input  logic             below_taper_i,
  input  logic             below_term_i,
  input  logic             temp_ok_i,
  input  logic             tj_hot_i,
  input  logic             bat_swap_i,
  input  logic             usb_hi_i,
  input  logic             tmr_en_i,
  input  logic             chg_rst_i,
  input  logic [1:0]       ac_derate_i,
  input  logic             fault_clr_i,
  input  logic [ACK_W-1:0] int_ack_i,
  output logic [1:0]       src_sel_o,
  output logic [1:0]       cur_mode_o,
  output logic [2:0]       cur_scale_o,
  output logic             pg_en_o,
  output logic [ST_W-1:0]  status_o
);
  localparam int unsigned NTMR = 4;
  localparam int unsigned LIMS [NTMR] = '{USB_DLY_TICKS, PRE_TICKS, FAST_TICKS, TAPER_TICKS};

  src_e src;
  cur_e cur;
  logic chg_en;
  logic [NTMR-1:0] t_run, t_clr, t_exp;

  li_chg_src u_src (
    .clk_i, .rst_ni, .ac_ok_i, .usb_ok_i, .ac_ovp_i, .chg_rst_i, .usb_hi_i, .ac_derate_i,
    .src_o(src), .pg_o(pg_en_o), .scale_o(cur_scale_o)
  );

  assign chg_en = (src != SRC_NONE) && !chg_rst_i;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    li_chg_tmr #(.LIMIT(LIMS[g])) u_tmr (
      .clk_i, .rst_ni, .clr_i(t_clr[g]), .run_i(t_run[g]), .exp_o(t_exp[g])
    );
  end

  li_chg_fsm u_fsm (
    .clk_i, .rst_ni, .src_i(src), .en_i(chg_en), .chg_rst_i, .tick_i,
    .bat_low_i, .bat_rch_i, .in_vreg_i, .below_taper_i, .below_term_i,
    .temp_ok_i, .tj_hot_i, .bat_swap_i, .tmr_en_i, .fault_clr_i, .int_ack_i,
    .usb_exp_i(t_exp[0]), .pre_exp_i(t_exp[1]), .fast_exp_i(t_exp[2]), .tap_exp_i(t_exp[3]),
    .usb_run_o(t_run[0]),  .usb_clr_o(t_clr[0]),
    .pre_run_o(t_run[1]),  .pre_clr_o(t_clr[1]),
    .fast_run_o(t_run[2]), .fast_clr_o(t_clr[2]),
    .tap_run_o(t_run[3]),  .tap_clr_o(t_clr[3]),
    .cur_o(cur), .status_o
  );

  assign src_sel_o  = src;
  assign cur_mode_o = cur;
endmodule

// File: rtl/li_chg_seq_chk.sv
module li_chg_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ac_ok_i,
  input logic       ac_ovp_i,
  input logic       below_term_i,
  input logic       temp_ok_i,
  input logic       tj_hot_i,
  input logic       bat_swap_i,
  input logic       fault_clr_i,
  input logic       chg_rst_i,
  input logic [1:0] src_sel_o,
  input logic [1:0] cur_mode_o,
  input logic       pg_en_o,
  input logic [7:0] status_o
);
  // R1
  src_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_sel_o != 2'd3 && $onehot0(src_sel_o));
  // R2
  ac_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_sel_o == 2'd1 |-> $past(ac_ok_i && !ac_ovp_i));
  // R6
  detect_in_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_mode_o == 2'd1 |-> status_o[5]);
  // R7
  fault_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[5]) |-> $past(bat_swap_i || fault_clr_i || chg_rst_i));
  // R8
  suspend_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!temp_ok_i || tj_hot_i) |-> (cur_mode_o != 2'd2 && cur_mode_o != 2'd3));
  // R11
  term_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[4]) |-> $past(below_term_i));
  // R13
  pg_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_rst_i |=> !pg_en_o);
endmodule

bind li_chg_seq li_chg_seq_chk u_chk (
  .clk_i, .rst_ni, .ac_ok_i, .ac_ovp_i, .below_term_i, .temp_ok_i, .tj_hot_i,
  .bat_swap_i, .fault_clr_i, .chg_rst_i, .src_sel_o, .cur_mode_o, .pg_en_o, .status_o
);

// File: tb/test_li_chg_seq.sv
module test_li_chg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {ac, usb, ovp, usb_hi, derate[1:0], chg_rst | src[1:0], pg, scale[2:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0000000_000000, 13'b1000000_011000, 13'b1100100_011010,
    13'b0100110_101100, 13'b0101110_101101, 13'b1111010_101101,
    13'b1010000_000000, 13'b1000110_011011, 13'b1000001_010000
  };

  logic clk = 0, rst_n = 0, tick = 0;
  logic ac_ok = 0, usb_ok = 0, ac_ovp = 0, bat_low = 0, bat_rch = 0, in_vreg = 0;
  logic below_taper = 0, below_term = 0, temp_ok = 1, tj_hot = 0, bat_swap = 0;
  logic usb_hi = 0, tmr_en = 0, chg_rst = 0, fault_clr = 0;
  logic [1:0] ac_derate = 0;
  logic [2:0] int_ack = 0;
  logic [1:0] src_sel, cur_mode;
  logic [2:0] cur_scale;
  logic pg_en;
  logic [7:0] status;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  li_chg_seq #(.USB_DLY_TICKS(3), .PRE_TICKS(4), .FAST_TICKS(6), .TAPER_TICKS(3)) i_li_chg_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ac_ok_i(ac_ok), .usb_ok_i(usb_ok),
    .ac_ovp_i(ac_ovp), .bat_low_i(bat_low), .bat_rch_i(bat_rch), .in_vreg_i(in_vreg),
    .below_taper_i(below_taper), .below_term_i(below_term), .temp_ok_i(temp_ok),
    .tj_hot_i(tj_hot), .bat_swap_i(bat_swap), .usb_hi_i(usb_hi), .tmr_en_i(tmr_en),
    .chg_rst_i(chg_rst), .ac_derate_i(ac_derate), .fault_clr_i(fault_clr),
    .int_ack_i(int_ack), .src_sel_o(src_sel), .cur_mode_o(cur_mode),
    .cur_scale_o(cur_scale), .pg_en_o(pg_en), .status_o(status)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick = 1;
      @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    check("R1 reset src", 8'(src_sel), 8'd0);
    check("R5 reset cur", 8'(cur_mode), 8'd0);
    check("R2 reset pg", 8'(pg_en), 8'd0);
    check("R5 reset status", status, 8'h00);
    rst_n = 1;
    step(1);

    // source, power-good and scale table: R1 R2 R4 R13
    for (int i = 0; i < NVEC; i++) begin
      {ac_ok, usb_ok, ac_ovp, usb_hi, ac_derate, chg_rst} = VEC[i][12:6];
      step(2);
      check("R1 src", 8'(src_sel), 8'(VEC[i][5:4]));
      check("R2 pg", 8'(pg_en), 8'(VEC[i][3]));
      check("R4 scale", 8'(cur_scale), 8'(VEC[i][2:0]));
    end
    {ac_ok, usb_ok, ac_ovp, usb_hi, ac_derate, chg_rst} = '0;
    step(3);
    check("R5 idle status", status, 8'h00);

    // precharge and its timeout
    bat_low = 1; ac_ok = 1;
    step(2);
    check("R5 precharge", 8'(cur_mode), 8'd2);
    check("R5 pre bit", 8'(status[0]), 8'd1);
    ticks(3);
    check("R6 before expiry", 8'(cur_mode), 8'd2);
    ticks(1);
    check("R6 detect", 8'(cur_mode), 8'd1);
    check("R6 fault bit", 8'(status[5]), 8'd1);
    ac_ok = 0; step(2); ac_ok = 1; step(2);
    check("R7 fault kept", 8'(status[5]), 8'd1);
    fault_clr = 1; step(1); fault_clr = 0; step(1);
    check("R7 clr", 8'(status[5]), 8'd0);
    check("R7 restart pre", 8'(cur_mode), 8'd2);

    // suspend freezes the precharge count
    ticks(2);
    temp_ok = 0; step(1);
    check("R8 off", 8'(cur_mode), 8'd0);
    ticks(5);
    temp_ok = 1; step(1);
    check("R8 resume", 8'(cur_mode), 8'd2);
    check("R8 sticky", 8'(status[6]), 8'd1);
    ticks(1);
    check("R8 held count", 8'(cur_mode), 8'd2);
    ticks(1);
    check("R8 held expiry", 8'(cur_mode), 8'd1);
    bat_swap = 1; step(1); bat_swap = 0; step(1);
    check("R7 swap", 8'(status[5]), 8'd0);
    int_ack = 3'b100; step(1); int_ack = 0;
    check("R14 ack suspend", 8'(status[6]), 8'd0);
    bat_low = 0; step(1);
    check("R5 to fast", 8'(cur_mode), 8'd3);

    // fast timer
    in_vreg = 1; below_taper = 1;
    ticks(10);
    check("R9 timers off", 8'(cur_mode), 8'd3);
    below_taper = 0; tmr_en = 1; step(1);
    ticks(5);
    in_vreg = 0; step(1); in_vreg = 1; step(1);
    ticks(5);
    check("R9 restart on vreg drop", 8'(cur_mode), 8'd3);
    ticks(1);
    check("R9 expiry", 8'(cur_mode), 8'd1);
    fault_clr = 1; step(1); fault_clr = 0; step(1);
    check("R9 fast again", 8'(cur_mode), 8'd3);

    // taper window
    below_taper = 1; ticks(2);
    below_taper = 0; step(1); below_taper = 1;
    ticks(2);
    check("R10 restart", 8'(cur_mode), 8'd3);
    ticks(1);
    check("R10 done", 8'(cur_mode), 8'd0);
    check("R10 bits", status & 8'h0C, 8'h0C);
    bat_rch = 1; step(1); bat_rch = 0;
    check("R12 recharge", 8'(cur_mode), 8'd3);
    check("R12 taper clr", 8'(status[3]), 8'd0);

    // termination
    below_taper = 0; below_term = 1; step(1); below_term = 0;
    check("R11 term", 8'(cur_mode), 8'd0);
    check("R11 bit", 8'(status[4]), 8'd1);
    bat_rch = 1; step(1); bat_rch = 0;
    check("R12 term clr", 8'(status[4]), 8'd0);

    // USB start delay
    ac_ok = 0; step(2);
    usb_ok = 1; usb_hi = 1; step(2);
    check("R3 waiting", 8'(cur_mode), 8'd0);
    check("R1 usb src", 8'(src_sel), 8'd2);
    check("R4 usb scale", 8'(cur_scale), 8'b101);
    ticks(2);
    check("R3 before delay", 8'(cur_mode), 8'd0);
    ticks(1);
    check("R3 after delay", 8'(cur_mode), 8'd3);
    ac_derate = 2'd3; step(1);
    check("R4 derate ignored on usb", 8'(cur_scale), 8'b101);

    // charger reset
    chg_rst = 1; step(2);
    check("R13 pg", 8'(pg_en), 8'd0);
    check("R13 cur", 8'(cur_mode), 8'd0);
    check("R13 idle", status & 8'h07, 8'h00);
    finish_run();
  end
endmodule